// File: doc/BRIEF.md
# 2D Block Transfer Address Sequencer

This block turns the description of one rectangular block into a stream of per-row transfer requests. The block is given by a start column in bytes, a start row, a width in bytes, a height in rows, and the base address and pitch of the surface that holds it. The data moves between that surface in memory and a packed register buffer. For each row the sequencer issues one request that carries three things: the surface byte address, the byte offset of that row inside the register buffer, and the number of bytes to move.

The register buffer uses its own row stride. This stride is the block width rounded up to a power of two, with a floor of 4 bytes. Because the buffer has a fixed size, the tallest legal block shrinks as the stride grows. The sequencer computes the stride and refuses any width/height pair that is out of range. A refused pair produces an error pulse and no requests.

Control uses a start/busy/done handshake. Requests leave on a valid/ready stream. Every transfer is a single lane, with no predicate and no channel mask.

Top module: `blk2d_addr_seq`

## Requirements
- R1: The register stride `reg_pitch_o` is 4 when the width is 4 or less. Otherwise it is the width rounded up to the next power of two (8, 16, 32 or 64). It is valid while `busy_o` is high.
- R2: A width of 0 or above 64 is illegal.
- R3: The height must be at least 1 and no more than a limit set by the stride: 64 rows for stride 4, 32 for stride 8, 16 for stride 16, 8 for stride 32, and 4 for stride 64.
- R4: When start is taken with an illegal pair, `err_o` is high for exactly one cycle, starting in the cycle after the start edge. No request is issued and `busy_o` stays low.
- R5: The request for row r carries the address base + (Y + r) × surface pitch + X, modulo 2^ADDR_W.
- R6: The request for row r carries the register offset r × stride.
- R7: Every request carries a byte count equal to the block width.
- R8: A legal start produces exactly `height` requests, in increasing row order. The first request is valid in the cycle after the start edge. `busy_o` is high from that cycle until the last request is accepted.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its fields do not change.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last request is accepted. In that cycle `busy_o` and `req_valid_o` are low.
- R11: A start pulse while `busy_o` is high is ignored. It has no effect on the block in progress.
- R12: After reset, `busy_o`, `req_valid_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| x_i | input | COORD_W | Block start column in bytes |
| y_i | input | COORD_W | Block start row |
| width_i | input | 7 | Block width in bytes |
| height_i | input | 7 | Block height in rows |
| base_i | input | ADDR_W | Surface base byte address |
| spitch_i | input | SPITCH_W | Surface row pitch in bytes |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse after the last row |
| err_o | output | 1 | One-cycle pulse on a refused start |
| reg_pitch_o | output | 7 | Register-buffer row stride |
| req_valid_o | output | 1 | Row request valid |
| req_ready_i | input | 1 | Row request accepted |
| req_addr_o | output | ADDR_W | Surface byte address of the row |
| req_roff_o | output | 8 | Register-buffer byte offset of the row |
| req_bytes_o | output | 7 | Bytes to move for the row |

## Verification
Both the error pulse and the first request, along with busy, appear one cycle after the start edge. Each later request appears one cycle after the previous one is accepted. Done appears one cycle after the last acceptance. The bench drives inputs one time unit after a rising edge and samples on the falling edge. A monitor counts the cycles and uses that count to check that done falls exactly one sample after the last popped request, and that a held request is unchanged at the next sample. Ready follows an irregular pattern so that stalls land on first, middle and last rows.

// File: rtl/blk2d_pkg.sv
package blk2d_pkg;
  localparam int DIM_W    = 7;    // width and height fields
  localparam int MAX_DIM  = 64;
  localparam int ROFF_W   = 8;    // register buffer offset
  localparam int REG_SPAN = 256;  // bytes in the register buffer

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // register stride: power of two, at least 4
  function automatic logic [DIM_W-1:0] stride_of(input logic [DIM_W-1:0] w);
    logic [DIM_W-1:0] p;
    p = DIM_W'(MAX_DIM);
    for (int k = 6; k >= 2; k--) begin
      if (w <= DIM_W'(1 << k)) p = DIM_W'(1 << k);
    end
    return p;
  endfunction
endpackage

// File: rtl/blk2d_limits.sv
module blk2d_limits
  import blk2d_pkg::*;
(
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [DIM_W-1:0] stride_o,
  output logic             legal_o
);
  localparam int PROD_W = 2 * DIM_W;

  logic [PROD_W-1:0] span;
  logic              w_ok;
  logic              h_ok;

  always_comb begin
    stride_o = stride_of(width_i);
    span     = PROD_W'(height_i) * PROD_W'(stride_o);
    w_ok     = (width_i != '0) && (width_i <= DIM_W'(MAX_DIM));
    h_ok     = (height_i != '0) && (span <= PROD_W'(REG_SPAN));
    legal_o  = w_ok && h_ok;
  end
endmodule

// File: rtl/blk2d_row_walk.sv
module blk2d_row_walk
  import blk2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SPITCH_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [ADDR_W-1:0]   addr0_i,
  input  logic [SPITCH_W-1:0] spitch_i,
  input  logic [DIM_W-1:0]    stride_i,
  input  logic [DIM_W-1:0]    rows_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ROFF_W-1:0]   roff_o,
  output logic [DIM_W-1:0]    stride_o,
  output logic                last_o
);
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ROFF_W-1:0]   roff_q, roff_d;
  logic [DIM_W-1:0]    left_q, left_d;
  logic [SPITCH_W-1:0] sp_q, sp_d;
  logic [DIM_W-1:0]    str_q, str_d;
  logic                en;

  always_comb begin
    en     = load_i | step_i;
    addr_d = addr_q + ADDR_W'(sp_q);
    roff_d = roff_q + ROFF_W'(str_q);
    left_d = left_q - 1'b1;
    sp_d   = sp_q;
    str_d  = str_q;
    if (load_i) begin
      addr_d = addr0_i;
      roff_d = '0;
      left_d = rows_i;
      sp_d   = spitch_i;
      str_d  = stride_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      roff_q <= '0;
      left_q <= '0;
      sp_q   <= '0;
      str_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      roff_q <= roff_d;
      left_q <= left_d;
      sp_q   <= sp_d;
      str_q  <= str_d;
    end
  end

  assign addr_o   = addr_q;
  assign roff_o   = roff_q;
  assign stride_o = str_q;
  assign last_o   = (left_q == DIM_W'(1));
endmodule

// File: rtl/blk2d_addr_seq.sv
module blk2d_addr_seq
  import blk2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int COORD_W  = 16,
  parameter int SPITCH_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [COORD_W-1:0]  x_i,
  input  logic [COORD_W-1:0]  y_i,
  input  logic [6:0]          width_i,
  input  logic [6:0]          height_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [SPITCH_W-1:0] spitch_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [6:0]          reg_pitch_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [7:0]          req_roff_o,
  output logic [6:0]          req_bytes_o
);
  seq_state_e        st_q, st_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DIM_W-1:0]  wid_q;
  logic [DIM_W-1:0]  stride;
  logic              legal;
  logic              take, load, step, last;
  logic [ADDR_W-1:0] addr0;

  blk2d_limits u_limits (
    .width_i  (width_i),
    .height_i (height_i),
    .stride_o (stride),
    .legal_o  (legal)
  );

  always_comb begin
    addr0 = base_i + ADDR_W'(y_i) * ADDR_W'(spitch_i) + ADDR_W'(x_i);
  end

  blk2d_row_walk #(
    .ADDR_W   (ADDR_W),
    .SPITCH_W (SPITCH_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .addr0_i  (addr0),
    .spitch_i (spitch_i),
    .stride_i (stride),
    .rows_i   (height_i),
    .addr_o   (req_addr_o),
    .roff_o   (req_roff_o),
    .stride_o (reg_pitch_o),
    .last_o   (last)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    take   = (st_q == SEQ_IDLE) && start_i;
    load   = take && legal;
    step   = (st_q == SEQ_RUN) && req_ready_i;
    unique case (st_q)
      SEQ_IDLE: begin
        if (take) begin
          if (legal) st_d = SEQ_RUN;
          else       err_d = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (req_ready_i && last) begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wid_q <= '0;
    else if (load) wid_q <= width_i;
  end

  assign busy_o      = (st_q == SEQ_RUN);
  assign req_valid_o = (st_q == SEQ_RUN);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign req_bytes_o = wid_q;
endmodule

// File: rtl/blk2d_addr_seq_chk.sv
module blk2d_addr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [6:0]        reg_pitch_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [7:0]        req_roff_o,
  input logic [6:0]        req_bytes_o
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
      && $stable(req_roff_o) && $stable(req_bytes_o)));

  p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !req_valid_o));

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !req_valid_o) ##1 !done_o);

  p_roff_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=>
      (!req_valid_o || req_roff_o == $past(req_roff_o) + 8'($past(reg_pitch_o))));

  p_pitch_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($onehot0(reg_pitch_o) && reg_pitch_o >= 7'd4));

  p_bytes_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_bytes_o != 7'd0 && req_bytes_o <= reg_pitch_o));
endmodule

bind blk2d_addr_seq blk2d_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .reg_pitch_o (reg_pitch_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_roff_o  (req_roff_o),
  .req_bytes_o (req_bytes_o)
);

// File: tb/test_blk2d_addr_seq.sv
`timescale 1ns/1ps
module test_blk2d_addr_seq;
  localparam int ADDR_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] x_i = '0, y_i = '0;
  logic [6:0]  width_i = '0, height_i = '0;
  logic [31:0] base_i = '0;
  logic [19:0] spitch_i = '0;
  logic        busy_o, done_o, err_o, req_valid_o, req_ready_i;
  logic [6:0]  reg_pitch_o, req_bytes_o;
  logic [31:0] req_addr_o;
  logic [7:0]  req_roff_o;

  int total = 0, bad = 0, cyc = 0, last_pop_cyc = -10;
  logic [46:0] expq[$];
  logic        held = 1'b0;
  logic [46:0] held_v;
  logic        ready_en = 1'b0;

  always #4 clk = ~clk;

  blk2d_addr_seq i_blk2d_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .y_i(y_i),
    .width_i(width_i), .height_i(height_i), .base_i(base_i), .spitch_i(spitch_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .reg_pitch_o(reg_pitch_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_roff_o(req_roff_o), .req_bytes_o(req_bytes_o));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_pitch(input int w);
    if (w <= 4) return 4;
    if (w <= 8) return 8;
    if (w <= 16) return 16;
    if (w <= 32) return 32;
    return 64;
  endfunction

  function automatic int exp_limit(input int p);
    case (p)
      4: return 64; 8: return 32; 16: return 16; 32: return 8;
      default: return 4;
    endcase
  endfunction

  // ready pattern: irregular stalls
  initial begin
    logic [7:0] lfsr = 8'h5a;
    req_ready_i = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready_i = ready_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (held) begin
        check(req_valid_o && {req_addr_o, req_roff_o, req_bytes_o} == held_v,
              "R9 hold", {req_addr_o, req_roff_o, req_bytes_o}, held_v);
        held = 1'b0;
      end
      if (req_valid_o && !req_ready_i) begin
        held = 1'b1;
        held_v = {req_addr_o, req_roff_o, req_bytes_o};
      end
      if (req_valid_o && req_ready_i) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8 extra request", {req_addr_o, req_roff_o, req_bytes_o}, 0);
        end else begin
          logic [46:0] e;
          e = expq.pop_front();
          check(req_addr_o == e[46:15], "R5 addr", req_addr_o, e[46:15]);
          check(req_roff_o == e[14:7], "R6 roff", req_roff_o, e[14:7]);
          check(req_bytes_o == e[6:0], "R7 bytes", req_bytes_o, e[6:0]);
          last_pop_cyc = cyc;
        end
      end
    end
  end

  task automatic run_block(input int x, input int y, input int w, input int h,
                           input logic [31:0] base, input int sp, input bit poke);
    int p = exp_pitch(w);
    bit legal = (w >= 1 && w <= 64 && h >= 1 && h <= exp_limit(p));
    if (legal) begin
      for (int r = 0; r < h; r++) begin
        logic [31:0] a = base + 32'((y + r) * sp + x);
        expq.push_back({a, 8'(r * p), 7'(w)});
      end
    end
    @(posedge clk); #1;
    x_i = 16'(x); y_i = 16'(y); width_i = 7'(w); height_i = 7'(h);
    base_i = base; spitch_i = 20'(sp); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    if (!legal) begin
      check(err_o == 1'b1, "R4 err pulse", err_o, 1);
      check(!busy_o && !req_valid_o, "R2 R3 refused no busy", busy_o, 0);
      @(negedge clk);
      check(err_o == 1'b0 && !req_valid_o, "R4 err one cycle", err_o, 0);
    end else begin
      check(busy_o && req_valid_o, "R8 busy after start", busy_o, 1);
      check(reg_pitch_o == 7'(p), "R1 stride", reg_pitch_o, p);
      check(!err_o, "R3 legal no err", err_o, 0);
      if (poke) begin
        // R11: start pulse with other values while busy
        @(posedge clk); #1;
        x_i = 16'h77; y_i = 16'h9; width_i = 7'd2; height_i = 7'd1; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
      end
      for (int g = 0; g < 2000 && !done_o; g++) @(negedge clk);
      check(done_o == 1'b1, "R10 done seen", done_o, 1);
      check(cyc == last_pop_cyc + 1, "R10 done timing", cyc, last_pop_cyc + 1);
      check(!busy_o && !req_valid_o, "R10 idle at done", busy_o, 0);
      check(expq.size() == 0, "R8 row count", expq.size(), 0);
      @(negedge clk);
      check(!done_o, "R10 done one cycle", done_o, 0);
      if (poke) check(!busy_o && !req_valid_o, "R11 poke ignored", busy_o, 0);
    end
  endtask

  initial begin
    #2000000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !req_valid_o && !done_o && !err_o, "R12 reset state", busy_o, 0);
    #1 rst_n = 1'b1;
    run_block(3, 2, 3, 5, 32'h1000, 256, 0);
    run_block(0, 0, 4, 64, 32'h0, 100, 0);
    ready_en = 1'b1;
    run_block(7, 10, 5, 32, 32'h8000, 640, 0);
    run_block(1, 3, 16, 16, 32'hffff_ff00, 1024, 1);
    run_block(100, 1, 17, 8, 32'h2000, 4096, 0);
    run_block(9, 9, 33, 4, 32'h4000, 512, 0);
    run_block(0, 40, 64, 4, 32'h10, 300, 0);
    run_block(2, 2, 1, 1, 32'h20, 64, 0);
    run_block(0, 0, 0, 4, 32'h0, 64, 0);
    run_block(0, 0, 65, 1, 32'h0, 64, 0);
    run_block(0, 0, 8, 33, 32'h0, 64, 0);
    run_block(0, 0, 64, 5, 32'h0, 64, 0);
    run_block(0, 0, 12, 0, 32'h0, 64, 0);
    run_block(0, 0, 33, 5, 32'h0, 64, 0);
    run_block(5, 6, 9, 16, 32'h300, 96, 0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule